// File: doc/BRIEF.md
# Legacy INTx Pulse Interrupt Collector

This block gathers the four legacy INTx interrupt events of a PCI Express root port. Each event arrives as a one-cycle pulse. The block stores it in a sticky status bit and combines the enabled status bits into one level interrupt toward the host processor. Each lane sits on an even bit of a 32-bit register word. Lane A uses bit 0, lane B bit 2, lane C bit 4 and lane D bit 6, and the bits between them are gaps.

Software services the interrupt in three steps. It reads the status word, handles the lanes it finds set, and writes the same word back. Writing a one clears that bit, so only the bits that were seen are cleared. An event that arrives while this is going on is never lost. A separate enable word selects which captured lanes drive the output. Capture into the status word happens whatever the enable setting is.

Top module: `intx_pulse_collector`

## Requirements
- R1: After reset, the status word and the enable word both read 0, and `irq_out` is low.
- R2: A pulse on `intx_evt[i]` sets status bit 2*i at the next rising clock edge, whatever the enable setting is (lane A is bit 0, B is bit 2, C is bit 4, D is bit 6).
- R3: A status bit stays set until software clears it. Idle cycles and writes to other offsets leave it unchanged.
- R4: A write to offset 0x000 clears each status bit 2*i for which the written word has a one at bit 2*i. Bits written as zero keep their value, so writing back a word just read clears exactly the bits that were set in it.
- R5: If an event on lane i and a clearing write to bit 2*i fall in the same cycle, the bit ends up set.
- R6: A write to offset 0x00C loads enable bit 2*i from bit 2*i of the written word. Writing 0x55 enables all four lanes, and the enable word reads back at offset 0x00C.
- R7: `irq_out` is high exactly when (status AND enable) is nonzero. It follows a change of status or enable from the same clock edge that changes the register.
- R8: Odd bits, and bits above bit 6, read as zero and ignore writes. Offsets other than 0x000 and 0x00C read as zero, and writes to them change nothing.
- R9: `acc_rdata` shows, within the same cycle, the word at `acc_addr`, with no read strobe and no wait cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears status and enable |
| intx_evt | input | 4 | One-cycle event pulses for lanes A to D |
| acc_addr | input | 12 | Register byte offset |
| acc_wr | input | 1 | Write strobe, one cycle per write |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr`, combinational |
| irq_out | output | 1 | Level interrupt: any enabled lane has a pending event |

## Verification
The assertions assume the following about the inputs:
- An event is a single-cycle pulse per lane.
- A write is a single-cycle strobe carrying a stable address and data.
- Reset is held for at least one clock edge.

Under these assumptions, the checker tests capture, hold, clearing, collision priority, the gap bits and the interrupt equation against the internal status and enable vectors. The bench drives random event patterns, offsets and write data that stay within those rules. About half of the status writes are exact read-back words, as real acknowledgement traffic would be. Directed cases add same-cycle collisions, writes of all ones, and accesses to unmapped offsets.

// File: rtl/intx_collect_pkg.sv
`timescale 1ns/1ps
package intx_collect_pkg;
   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_STATUS = 2'd1,
      ACC_ENABLE = 2'd2
   } acc_kind_e;

   function automatic int unsigned lane_pos(input int unsigned idx, input int unsigned stride);
      return idx * stride;
   endfunction
endpackage

// File: rtl/intx_lane.sv
`timescale 1ns/1ps
// One lane: a sticky status flop plus its enable flop.
module intx_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic stat_clr_wr,
   input  logic en_wr,
   input  logic wbit,
   output logic stat_q,
   output logic en_q
);
   logic stat_d;
   logic en_d;

   // A new event takes priority over a clear in the same cycle.
   always_comb begin
      stat_d = stat_q;
      if (stat_clr_wr && wbit) stat_d = 1'b0;
      if (evt)                 stat_d = 1'b1;
      en_d = en_wr ? wbit : en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         stat_q <= stat_d;
         en_q   <= en_d;
      end
   end
endmodule

// File: rtl/intx_reg_decode.sv
`timescale 1ns/1ps
// Decodes the offset, extracts the lane bits being written, and builds the read word.
module intx_reg_decode
   import intx_collect_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned LANE_STRIDE = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] STATUS_OFS = '0,
   parameter logic [ADDR_W-1:0] ENABLE_OFS = ADDR_W'(12)
) (
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic                 acc_wr,
   input  logic [DATA_W-1:0]    acc_wdata,
   input  logic [NUM_LINES-1:0] stat_vec,
   input  logic [NUM_LINES-1:0] en_vec,
   output logic                 wr_status,
   output logic                 wr_enable,
   output logic [NUM_LINES-1:0] lane_wbits,
   output logic [DATA_W-1:0]    acc_rdata
);
   acc_kind_e kind;
   logic unused_wdata;

   assign unused_wdata = ^acc_wdata;

   always_comb begin
      if (acc_addr == STATUS_OFS)      kind = ACC_STATUS;
      else if (acc_addr == ENABLE_OFS) kind = ACC_ENABLE;
      else                             kind = ACC_NONE;
   end

   assign wr_status = acc_wr && (kind == ACC_STATUS);
   assign wr_enable = acc_wr && (kind == ACC_ENABLE);

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_wbit
      assign lane_wbits[g] = acc_wdata[lane_pos(g, LANE_STRIDE)];
   end

   always_comb begin
      acc_rdata = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         case (kind)
            ACC_STATUS: acc_rdata[lane_pos(i, LANE_STRIDE)] = stat_vec[i];
            ACC_ENABLE: acc_rdata[lane_pos(i, LANE_STRIDE)] = en_vec[i];
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/intx_irq_merge.sv
`timescale 1ns/1ps
// Combines the enabled status bits; REG_IRQ selects a direct or a flopped output.
module intx_irq_merge #(
   parameter int unsigned NUM_LINES = 4,
   parameter bit          REG_IRQ   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] stat_vec,
   input  logic [NUM_LINES-1:0] en_vec,
   output logic                 irq_out
);
   logic any_pending;
   assign any_pending = |(stat_vec & en_vec);

   if (REG_IRQ) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= any_pending;
      end
   end else begin : g_direct
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_out = any_pending;
   end
endmodule

// File: rtl/intx_pulse_collector.sv
`timescale 1ns/1ps
module intx_pulse_collector #(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned LANE_STRIDE = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] STATUS_OFS = '0,
   parameter logic [ADDR_W-1:0] ENABLE_OFS = ADDR_W'(12),
   parameter bit          REG_IRQ     = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] intx_evt,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic                 acc_wr,
   input  logic [DATA_W-1:0]    acc_wdata,
   output logic [DATA_W-1:0]    acc_rdata,
   output logic                 irq_out
);
   localparam int unsigned TOP_BIT = (NUM_LINES - 1) * LANE_STRIDE;

   if (TOP_BIT >= DATA_W) begin : g_bad_width
      $error("lane bits do not fit in the data word");
   end
   if (STATUS_OFS == ENABLE_OFS) begin : g_bad_ofs
      $error("status and enable offsets collide");
   end
   if (LANE_STRIDE == 0) begin : g_bad_stride
      $error("lane stride must be nonzero");
   end

   logic [NUM_LINES-1:0] stat_vec;
   logic [NUM_LINES-1:0] en_vec;
   logic [NUM_LINES-1:0] lane_wbits;
   logic                 wr_status;
   logic                 wr_enable;

   intx_reg_decode #(
      .NUM_LINES(NUM_LINES), .LANE_STRIDE(LANE_STRIDE), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS)
   ) u_dec (
      .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .stat_vec(stat_vec), .en_vec(en_vec),
      .wr_status(wr_status), .wr_enable(wr_enable),
      .lane_wbits(lane_wbits), .acc_rdata(acc_rdata)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
      intx_lane u_lane (
         .clk(clk), .rst_n(rst_n), .evt(intx_evt[g]),
         .stat_clr_wr(wr_status), .en_wr(wr_enable), .wbit(lane_wbits[g]),
         .stat_q(stat_vec[g]), .en_q(en_vec[g])
      );
   end

   intx_irq_merge #(.NUM_LINES(NUM_LINES), .REG_IRQ(REG_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat_vec(stat_vec), .en_vec(en_vec),
      .irq_out(irq_out)
   );
endmodule

// File: rtl/intx_pulse_collector_chk.sv
`timescale 1ns/1ps
module intx_pulse_collector_chk #(
   parameter int unsigned NUM_LINES   = 4,
   parameter int unsigned LANE_STRIDE = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter logic [ADDR_W-1:0] STATUS_OFS = '0,
   parameter logic [ADDR_W-1:0] ENABLE_OFS = ADDR_W'(12),
   parameter bit          REG_IRQ     = 1'b0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] intx_evt,
   input logic [ADDR_W-1:0]    acc_addr,
   input logic                 acc_wr,
   input logic [DATA_W-1:0]    acc_wdata,
   input logic [DATA_W-1:0]    acc_rdata,
   input logic                 irq_out,
   input logic [NUM_LINES-1:0] stat_vec,
   input logic [NUM_LINES-1:0] en_vec
);
   function automatic logic [NUM_LINES-1:0] gather(input logic [DATA_W-1:0] w);
      for (int i = 0; i < NUM_LINES; i++) gather[i] = w[i * LANE_STRIDE];
   endfunction

   function automatic logic [DATA_W-1:0] lane_mask();
      lane_mask = '0;
      for (int i = 0; i < NUM_LINES; i++) lane_mask[i * LANE_STRIDE] = 1'b1;
   endfunction

   logic stat_wr, en_wr;
   assign stat_wr = acc_wr && (acc_addr == STATUS_OFS);
   assign en_wr   = acc_wr && (acc_addr == ENABLE_OFS);

   assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (intx_evt != '0) |=> ((stat_vec & $past(intx_evt)) == $past(intx_evt)));

   // R5: the set side wins over a same-cycle clear
   assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && ((gather(acc_wdata) & intx_evt) != '0))
      |=> ((stat_vec & $past(intx_evt)) == $past(intx_evt)));

   assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

   assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((stat_vec & $past(gather(acc_wdata)) & ~$past(intx_evt)) == '0));

   assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_vec));

   assert_gap_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rdata & ~lane_mask()) == '0);

   if (REG_IRQ) begin : g_irq_flop
      assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_out == $past(|(stat_vec & en_vec))));
   end else begin : g_irq_direct
      assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out == |(stat_vec & en_vec));
   end
endmodule

bind intx_pulse_collector intx_pulse_collector_chk #(
   .NUM_LINES(NUM_LINES), .LANE_STRIDE(LANE_STRIDE), .DATA_W(DATA_W),
   .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .ENABLE_OFS(ENABLE_OFS),
   .REG_IRQ(REG_IRQ)
) u_chk (
   .clk(clk), .rst_n(rst_n), .intx_evt(intx_evt), .acc_addr(acc_addr),
   .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
   .irq_out(irq_out), .stat_vec(stat_vec), .en_vec(en_vec)
);

// File: tb/intx_pulse_collector_test.sv
`timescale 1ns/1ps
module intx_pulse_collector_test;
   localparam logic [11:0] OFS_STAT = 12'h000;
   localparam logic [11:0] OFS_EN   = 12'h00C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  intx_evt = '0;
   logic [11:0] acc_addr = '0;
   logic        acc_wr = 1'b0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        irq_out;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [3:0] m_stat = '0;
   logic [3:0] m_en = '0;

   always #10 clk = ~clk;

   intx_pulse_collector uut (
      .clk(clk), .rst_n(rst_n), .intx_evt(intx_evt), .acc_addr(acc_addr),
      .acc_wr(acc_wr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .irq_out(irq_out)
   );

   function automatic logic [3:0] pick(input logic [31:0] w);
      return {w[6], w[4], w[2], w[0]};
   endfunction

   function automatic logic [31:0] spread(input logic [3:0] v);
      return {25'd0, v[3], 1'b0, v[2], 1'b0, v[1], 1'b0, v[0]};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic step(input logic [3:0] e, input logic w, input logic [11:0] a,
                       input logic [31:0] d);
      @(negedge clk);
      intx_evt = e; acc_wr = w; acc_addr = a; acc_wdata = d;
      @(posedge clk);
      #2;
      m_stat = e | (m_stat & ~((w && a == OFS_STAT) ? pick(d) : 4'h0));
      if (w && a == OFS_EN) m_en = pick(d);
      intx_evt = '0; acc_wr = 1'b0;
      check("R7 irq", {31'd0, irq_out}, {31'd0, |(m_stat & m_en)});
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      acc_addr = a;
      #1;
      check(req, acc_rdata, exp);
   endtask

   initial begin
      #(20 * 150000);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A5C));
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      rd("R1 status", OFS_STAT, 32'h0);
      rd("R1 enable", OFS_EN, 32'h0);
      check("R1 irq", {31'd0, irq_out}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      // R2 capture with lanes disabled, irq stays low
      step(4'b0010, 1'b0, OFS_STAT, 32'h0);
      rd("R2 lane B capture", OFS_STAT, 32'h0000_0004);
      check("R2 no irq while disabled", {31'd0, irq_out}, 32'h0);
      // R3 hold over idle cycles
      for (int k = 0; k < 5; k++) step(4'b0000, 1'b0, OFS_STAT, 32'h0);
      rd("R3 hold", OFS_STAT, 32'h0000_0004);
      // R6 enable all with 0x55
      step(4'b0000, 1'b1, OFS_EN, 32'h0000_0055);
      rd("R6 enable readback", OFS_EN, 32'h0000_0055);
      check("R7 irq after enable", {31'd0, irq_out}, 32'h1);
      // R8 gap bits ignore writes
      step(4'b0000, 1'b1, OFS_EN, 32'hFFFF_FFFF);
      rd("R8 enable gaps", OFS_EN, 32'h0000_0055);
      // R4 writing zeros keeps status
      step(4'b0000, 1'b1, OFS_STAT, 32'h0000_0000);
      rd("R4 zero write", OFS_STAT, 32'h0000_0004);
      // R4 read then write back
      step(4'b0000, 1'b1, OFS_STAT, 32'h0000_0004);
      rd("R4 writeback clear", OFS_STAT, 32'h0);
      check("R7 irq drops", {31'd0, irq_out}, 32'h0);
      // R5 collision: lane A set and cleared in the same cycle
      step(4'b0001, 1'b0, OFS_STAT, 32'h0);
      step(4'b0001, 1'b1, OFS_STAT, 32'h0000_0001);
      rd("R5 set wins", OFS_STAT, 32'h0000_0001);
      // R8 unmapped offset: reads zero, write has no effect
      step(4'b0000, 1'b1, 12'h004, 32'hFFFF_FFFF);
      rd("R8 unmapped read", 12'h004, 32'h0);
      rd("R8 status untouched", OFS_STAT, 32'h0000_0001);
      rd("R8 enable untouched", OFS_EN, 32'h0000_0055);

      // R9 random traffic against the bench model
      for (int it = 0; it < 400; it++) begin
         logic [3:0]  e;
         logic        w;
         logic [11:0] a;
         logic [31:0] d;
         int unsigned sel;
         e = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
         w = ($urandom % 2) == 1;
         sel = $urandom % 4;
         a = (sel == 0) ? OFS_STAT : (sel == 1) ? OFS_EN : (sel == 2) ? OFS_STAT : 12'h010;
         d = ($urandom % 2 == 1) ? spread(m_stat) : $urandom;
         step(e, w, a, d);
         rd("R9 status", OFS_STAT, spread(m_stat));
         rd("R9 enable", OFS_EN, spread(m_en));
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule